// File: doc/BRIEF.md
# Subaddressed Serial Configuration Register File

This block is a write-only two-wire serial slave in front of fourteen 8-bit configuration registers. A bus master addresses the device, sends one subaddress byte, and then sends data bytes. The subaddress chooses between two kinds of transfer. The first writes a single named register. The second loads the whole file in index order, starting at index 0. Two static select pins give the device one of four bus addresses, so four instances can share one bus. A disable level makes the slave deaf to the bus.

The bus lines are not used as clocks. SCL and SDA are sampled and synchronised in the system clock domain, and START, STOP and SCL edges are recovered from the sampled levels. The slave drives SDA only through an open-drain pull-low enable.

The register contents are not read back over the bus. They are decoded into named fields that the surrounding logic consumes:
- per-channel 9-bit offset codes, 7-bit coarse gains and 5-bit fine gains;
- control flags;
- a loop filter code and a VCO range code;
- a 12-bit divider ratio;
- two phase codes with their clock routing bits.

Two of these fields take their bits from more than one register.

Top module: `cfgser_regfile`

## Requirements
- R1: The slave answers only the 7-bit address {DEV_BASE[6:2], addr_sel[1:0]} when the R/W bit (last bit of the address byte) is 0. For that address it pulls SDA low in the 9th clock. It does not acknowledge any other address or a read request, and it ignores the rest of that transfer until the next START.
- R2: The first byte after the address is the subaddress: bit 4 is the mode flag, bits 3..0 are the register index. The slave acknowledges it.
- R3: With the mode flag at 0, the first data byte writes the indexed register. Further data bytes in the same transfer are acknowledged but change nothing.
- R4: With the mode flag at 1 and index 1111, successive data bytes write registers 0, 1, 2 … 13 in order.
- R5: A burst writes no more after register 13; extra bytes are still acknowledged. A STOP or a repeated START ends a transfer, and the next transfer starts from its own subaddress.
- R6: A single-mode write to index 14 or 15 is acknowledged and changes no register.
- R7: While bus_off is 1, the slave never pulls SDA and no register changes.
- R8: After reset the registers hold the following values:
  - 0x7F at indices 0, 3 and 6;
  - 0x20 at indices 1, 4 and 7;
  - 0x00 at indices 2, 5 and 8;
  - 0x04 at index 9, 0x61 at index 10, 0x90 at index 11;
  - 0x00 at indices 12 and 13.

  With these values div_ratio is 800.
- R9: Channel c (0..2) uses registers 3c, 3c+1 and 3c+2:
  - the offset code is {reg[3c+1][7], reg[3c]};
  - the coarse gain is reg[3c+1][6:0];
  - the fine gain is reg[3c+2][4:0].

  Each field is packed at bit c*9, c*7 and c*5 of its output bus.
- R10: div_ratio = {reg10[2:0], reg11[7:0], reg12[6]}. It reaches 4095 when all of these bits are 1.
- R11: The remaining fields decode as follows:
  - reg9 bits 7..0 are coast_invert, hsync_invert, ref_fall_edge, pump_force_up, pump_force_dn and pump_current[2:0];
  - reg10[7:5] is filter_res and reg10[4:3] is vco_range;
  - reg12[4:0] is phase_a and reg12[5] is clk_a_select;
  - reg13[4:0] is phase_b, reg13[5] is clk_b_select and reg13[6] is clk_ab_swap.
- R12: sda_pull rises only after a sampled falling SCL edge. It is released at the next falling edge, so it covers exactly one bit slot, and it is 0 after a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_sel | input | 2 | Low two bits of the device address |
| bus_off | input | 1 | 1 = ignore all bus traffic |
| scl_in | input | 1 | Sampled serial clock line |
| sda_in | input | 1 | Sampled serial data line |
| sda_pull | output | 1 | 1 = pull SDA low (open drain) |
| offset_code | output | 27 | Three 9-bit offset codes, channel 0 lowest |
| coarse_gain | output | 21 | Three 7-bit coarse gains |
| fine_gain | output | 15 | Three 5-bit fine gains |
| coast_invert | output | 1 | Control flag reg9[7] |
| hsync_invert | output | 1 | Control flag reg9[6] |
| ref_fall_edge | output | 1 | Control flag reg9[5] |
| pump_force_up | output | 1 | Test flag reg9[4] |
| pump_force_dn | output | 1 | Test flag reg9[3] |
| pump_current | output | 3 | reg9[2:0] |
| filter_res | output | 3 | reg10[7:5] |
| vco_range | output | 2 | reg10[4:3] |
| div_ratio | output | 12 | Divider ratio assembled from three registers |
| phase_a | output | 5 | reg12[4:0] |
| clk_a_select | output | 1 | reg12[5] |
| phase_b | output | 5 | reg13[4:0] |
| clk_b_select | output | 1 | reg13[5] |
| clk_ab_swap | output | 1 | reg13[6] |

## Verification
The hardest state to reach from the pins is a burst pointer that has passed index 13 while the master keeps clocking bytes. That state is also the one that decides whether a stale pointer survives into the next transfer. The bench drives sixteen-byte bursts to get there, and it cuts a burst short with a repeated START followed by a single write. Every register is then compared against a bench-side image that is updated only from the stated rules. The address sweep tries all four addresses against all four select settings. It also tries a read request and an unmatched address that is followed by bytes which must not land.

// File: rtl/cfgser_pkg.sv
package cfgser_pkg;

    localparam int NUM_CH      = 3;
    localparam int REGS_PER_CH = 3;
    localparam int NUM_REGS    = NUM_CH * REGS_PER_CH + 5;
    localparam int IDX_W       = 4;
    localparam int OFS_W       = 9;
    localparam int CRS_W       = 7;
    localparam int FIN_W       = 5;
    localparam int DIV_W       = 12;

    localparam int IDX_CTRL  = NUM_CH * REGS_PER_CH;
    localparam int IDX_VCO   = IDX_CTRL + 1;
    localparam int IDX_DIV   = IDX_CTRL + 2;
    localparam int IDX_PHA   = IDX_CTRL + 3;
    localparam int IDX_PHB   = IDX_CTRL + 4;

    localparam logic [IDX_W-1:0] BURST_IDX = '1;

    typedef enum logic [1:0] {PH_IDLE, PH_RX, PH_ACK} phase_t;
    typedef enum logic [1:0] {STG_DEV, STG_SUB, STG_DATA} stage_t;

    typedef struct packed {
        logic             en;
        logic [IDX_W-1:0] idx;
        logic [7:0]       data;
    } wr_req_t;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_evt_t;

    function automatic logic [7:0] reg_default(input int idx);
        logic [7:0] v;
        if (idx < IDX_CTRL) begin
            case (idx % REGS_PER_CH)
                0:       v = 8'h7F;
                1:       v = 8'h20;
                default: v = 8'h00;
            endcase
        end else if (idx == IDX_CTRL) begin
            v = 8'h04;
        end else if (idx == IDX_VCO) begin
            v = 8'h61;
        end else if (idx == IDX_DIV) begin
            v = 8'h90;
        end else begin
            v = 8'h00;
        end
        return v;
    endfunction

endpackage

// File: rtl/cfgser_edge_sync.sv
module cfgser_edge_sync
    import cfgser_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output bus_evt_t evt
);
    logic [SYNC_STAGES-1:0] scl_sr, sda_sr;
    logic scl_prev, sda_prev;
    logic scl_s, sda_s;

    assign scl_s = scl_sr[SYNC_STAGES-1];
    assign sda_s = sda_sr[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sr   <= '1;
            sda_sr   <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_sr   <= {scl_sr[SYNC_STAGES-2:0], scl_in};
            sda_sr   <= {sda_sr[SYNC_STAGES-2:0], sda_in};
            scl_prev <= scl_s;
            sda_prev <= sda_s;
        end
    end

    always_comb begin
        evt.scl_rise = scl_s & ~scl_prev;
        evt.scl_fall = ~scl_s & scl_prev;
        evt.start    = scl_s & scl_prev & sda_prev & ~sda_s;
        evt.stop     = scl_s & scl_prev & ~sda_prev & sda_s;
        evt.sda      = sda_s;
    end
endmodule

// File: rtl/cfgser_byte_engine.sv
module cfgser_byte_engine
    import cfgser_pkg::*;
#(
    parameter logic [6:0] DEV_BASE = 7'h4C
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_off,
    input  logic [1:0] addr_sel,
    input  bus_evt_t   evt,
    output logic       sda_pull,
    output wr_req_t    wr
);
    localparam logic [4:0] PTR_END = 5'(NUM_REGS);

    phase_t     phase;
    stage_t     stage;
    logic [7:0] shreg;
    logic [3:0] bitcnt;
    logic       byte_full;
    logic [4:0] ptr;
    logic       burst;
    logic       single_done;
    logic [6:0] my_addr;

    assign my_addr = {DEV_BASE[6:2], addr_sel};

    always_ff @(posedge clk) begin
        if (rst || bus_off) begin
            phase       <= PH_IDLE;
            stage       <= STG_DEV;
            shreg       <= '0;
            bitcnt      <= '0;
            byte_full   <= 1'b0;
            ptr         <= '0;
            burst       <= 1'b0;
            single_done <= 1'b0;
            sda_pull    <= 1'b0;
            wr          <= '0;
        end else begin
            wr.en <= 1'b0;
            if (evt.start) begin
                phase     <= PH_RX;
                stage     <= STG_DEV;
                bitcnt    <= '0;
                byte_full <= 1'b0;
                sda_pull  <= 1'b0;
            end else if (evt.stop) begin
                phase    <= PH_IDLE;
                sda_pull <= 1'b0;
            end else begin
                case (phase)
                    PH_RX: begin
                        if (evt.scl_rise && !byte_full) begin
                            shreg  <= {shreg[6:0], evt.sda};
                            bitcnt <= bitcnt + 4'd1;
                            if (bitcnt == 4'd7) byte_full <= 1'b1;
                        end else if (evt.scl_fall && byte_full) begin
                            byte_full <= 1'b0;
                            bitcnt    <= '0;
                            case (stage)
                                STG_DEV: begin
                                    if (shreg[7:1] == my_addr && !shreg[0]) begin
                                        sda_pull <= 1'b1;
                                        phase    <= PH_ACK;
                                        stage    <= STG_SUB;
                                    end else begin
                                        phase <= PH_IDLE;
                                    end
                                end
                                STG_SUB: begin
                                    sda_pull    <= 1'b1;
                                    phase       <= PH_ACK;
                                    stage       <= STG_DATA;
                                    single_done <= 1'b0;
                                    if (shreg[4] && shreg[3:0] == BURST_IDX) begin
                                        burst <= 1'b1;
                                        ptr   <= '0;
                                    end else begin
                                        burst <= 1'b0;
                                        ptr   <= {1'b0, shreg[3:0]};
                                    end
                                end
                                default: begin
                                    sda_pull <= 1'b1;
                                    phase    <= PH_ACK;
                                    if (ptr < PTR_END && !single_done) begin
                                        wr.en   <= 1'b1;
                                        wr.idx  <= ptr[3:0];
                                        wr.data <= shreg;
                                    end
                                    if (burst) begin
                                        if (ptr < PTR_END) ptr <= ptr + 5'd1;
                                    end else begin
                                        single_done <= 1'b1;
                                    end
                                end
                            endcase
                        end
                    end
                    PH_ACK: begin
                        if (evt.scl_fall) begin
                            sda_pull <= 1'b0;
                            phase    <= PH_RX;
                        end
                    end
                    default: begin
                        sda_pull <= 1'b0;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/cfgser_reg_store.sv
module cfgser_reg_store
    import cfgser_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  wr_req_t               wr,
    output logic [NUM_REGS*8-1:0] regs_flat
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs_flat[i*8 +: 8] <= reg_default(i);
            end else if (wr.en && wr.idx == IDX_W'(i)) begin
                regs_flat[i*8 +: 8] <= wr.data;
            end
        end
    end
endmodule

// File: rtl/cfgser_field_map.sv
module cfgser_field_map
    import cfgser_pkg::*;
(
    input  logic [NUM_REGS*8-1:0]     regs_flat,
    output logic [NUM_CH*OFS_W-1:0]   offset_code,
    output logic [NUM_CH*CRS_W-1:0]   coarse_gain,
    output logic [NUM_CH*FIN_W-1:0]   fine_gain,
    output logic [7:0]                ctrl_bits,
    output logic [2:0]                filter_res,
    output logic [1:0]                vco_range,
    output logic [DIV_W-1:0]          div_ratio,
    output logic [4:0]                phase_a,
    output logic                      clk_a_select,
    output logic [4:0]                phase_b,
    output logic                      clk_b_select,
    output logic                      clk_ab_swap
);
    logic [7:0] r [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_unpack
        assign r[i] = regs_flat[i*8 +: 8];
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int B = c * REGS_PER_CH;
        assign offset_code[c*OFS_W +: OFS_W] = {r[B+1][7], r[B]};
        assign coarse_gain[c*CRS_W +: CRS_W] = r[B+1][CRS_W-1:0];
        assign fine_gain[c*FIN_W +: FIN_W]   = r[B+2][FIN_W-1:0];
    end

    assign ctrl_bits    = r[IDX_CTRL];
    assign filter_res   = r[IDX_VCO][7:5];
    assign vco_range    = r[IDX_VCO][4:3];
    assign div_ratio    = {r[IDX_VCO][2:0], r[IDX_DIV], r[IDX_PHA][6]};
    assign phase_a      = r[IDX_PHA][4:0];
    assign clk_a_select = r[IDX_PHA][5];
    assign phase_b      = r[IDX_PHB][4:0];
    assign clk_b_select = r[IDX_PHB][5];
    assign clk_ab_swap  = r[IDX_PHB][6];

    logic unused_bits;
    assign unused_bits = ^{r[2][7:5], r[5][7:5], r[8][7:5], r[IDX_PHA][7], r[IDX_PHB][7]};
endmodule

// File: rtl/cfgser_regfile.sv
module cfgser_regfile
    import cfgser_pkg::*;
#(
    parameter logic [6:0] DEV_BASE    = 7'h4C,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [1:0]                  addr_sel,
    input  logic                        bus_off,
    input  logic                        scl_in,
    input  logic                        sda_in,
    output logic                        sda_pull,
    output logic [NUM_CH*OFS_W-1:0]     offset_code,
    output logic [NUM_CH*CRS_W-1:0]     coarse_gain,
    output logic [NUM_CH*FIN_W-1:0]     fine_gain,
    output logic                        coast_invert,
    output logic                        hsync_invert,
    output logic                        ref_fall_edge,
    output logic                        pump_force_up,
    output logic                        pump_force_dn,
    output logic [2:0]                  pump_current,
    output logic [2:0]                  filter_res,
    output logic [1:0]                  vco_range,
    output logic [DIV_W-1:0]            div_ratio,
    output logic [4:0]                  phase_a,
    output logic                        clk_a_select,
    output logic [4:0]                  phase_b,
    output logic                        clk_b_select,
    output logic                        clk_ab_swap
);
    bus_evt_t              evt;
    wr_req_t               wr;
    logic [NUM_REGS*8-1:0] regs_flat;
    logic [7:0]            ctrl_bits;
    logic                  scl_fall_w;
    logic                  wr_en_w;
    logic [IDX_W-1:0]      wr_idx_w;

    cfgser_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in), .evt(evt)
    );

    cfgser_byte_engine #(.DEV_BASE(DEV_BASE)) eng_i (
        .clk(clk), .rst(rst), .bus_off(bus_off), .addr_sel(addr_sel),
        .evt(evt), .sda_pull(sda_pull), .wr(wr)
    );

    cfgser_reg_store store_i (
        .clk(clk), .rst(rst), .wr(wr), .regs_flat(regs_flat)
    );

    cfgser_field_map map_i (
        .regs_flat(regs_flat), .offset_code(offset_code), .coarse_gain(coarse_gain),
        .fine_gain(fine_gain), .ctrl_bits(ctrl_bits), .filter_res(filter_res),
        .vco_range(vco_range), .div_ratio(div_ratio), .phase_a(phase_a),
        .clk_a_select(clk_a_select), .phase_b(phase_b), .clk_b_select(clk_b_select),
        .clk_ab_swap(clk_ab_swap)
    );

    assign {coast_invert, hsync_invert, ref_fall_edge, pump_force_up,
            pump_force_dn, pump_current} = ctrl_bits;

    assign scl_fall_w = evt.scl_fall;
    assign wr_en_w    = wr.en;
    assign wr_idx_w   = wr.idx;
endmodule

// File: rtl/cfgser_regfile_chk.sv
module cfgser_regfile_chk
    import cfgser_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             bus_off,
    input logic             sda_pull,
    input logic             scl_fall,
    input logic             wr_en,
    input logic [IDX_W-1:0] wr_idx,
    input logic [DIV_W-1:0] div_ratio
);
    assert_off_silent_R7: assert property (@(posedge clk) disable iff (rst)
        $past(bus_off) |-> (!sda_pull && !wr_en));

    assert_ack_after_fall_R12: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull) |-> $past(scl_fall));

    assert_write_in_range_R5: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_idx < IDX_W'(NUM_REGS)));

    assert_div_default_R8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (div_ratio == 12'd800));

    assert_hold_no_write_R3: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(div_ratio));
endmodule

bind cfgser_regfile cfgser_regfile_chk chk_i (
    .clk(clk), .rst(rst), .bus_off(bus_off), .sda_pull(sda_pull),
    .scl_fall(scl_fall_w), .wr_en(wr_en_w), .wr_idx(wr_idx_w), .div_ratio(div_ratio)
);

// File: tb/cfgser_regfile_tb_top.sv
module cfgser_regfile_tb_top;
    localparam logic [6:0] BASE = 7'h4C;
    localparam int H = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] addr_sel = 2'd0;
    logic bus_off = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_line;
    logic sda_pull;
    logic [26:0] offset_code;
    logic [20:0] coarse_gain;
    logic [14:0] fine_gain;
    logic coast_invert, hsync_invert, ref_fall_edge, pump_force_up, pump_force_dn;
    logic [2:0] pump_current, filter_res;
    logic [1:0] vco_range;
    logic [11:0] div_ratio;
    logic [4:0] phase_a, phase_b;
    logic clk_a_select, clk_b_select, clk_ab_swap;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [7:0] model [14];
    logic [7:0] dbuf [16];

    always #10 clk = ~clk;
    assign sda_line = m_sda & ~sda_pull;

    cfgser_regfile dut_i (
        .clk(clk), .rst(rst), .addr_sel(addr_sel), .bus_off(bus_off),
        .scl_in(m_scl), .sda_in(sda_line), .sda_pull(sda_pull),
        .offset_code(offset_code), .coarse_gain(coarse_gain), .fine_gain(fine_gain),
        .coast_invert(coast_invert), .hsync_invert(hsync_invert),
        .ref_fall_edge(ref_fall_edge), .pump_force_up(pump_force_up),
        .pump_force_dn(pump_force_dn), .pump_current(pump_current),
        .filter_res(filter_res), .vco_range(vco_range), .div_ratio(div_ratio),
        .phase_a(phase_a), .clk_a_select(clk_a_select), .phase_b(phase_b),
        .clk_b_select(clk_b_select), .clk_ab_swap(clk_ab_swap)
    );

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bus_start;
        m_sda = 1'b1; wt(H); m_scl = 1'b1; wt(H);
        m_sda = 1'b0; wt(H); m_scl = 1'b0; wt(H);
    endtask

    task automatic bus_stop;
        m_sda = 1'b0; wt(H); m_scl = 1'b1; wt(H); m_sda = 1'b1; wt(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            wt(2); m_sda = b[i]; wt(H);
            m_scl = 1'b1; wt(H); m_scl = 1'b0;
        end
        wt(2); m_sda = 1'b1; wt(H);
        m_scl = 1'b1; wt(H / 2);
        ack = ~sda_line;
        wt(H / 2); m_scl = 1'b0; wt(2);
    endtask

    // address byte, subaddress, then n bytes from dbuf; all acks must equal exp_ack
    task automatic xfer(input string tag, input logic [6:0] dev, input logic [7:0] sub,
                        input int n, input logic exp_ack, input bit do_stop);
        logic a;
        bus_start;
        send_byte({dev, 1'b0}, a); chk({tag, " addr ack"}, a, exp_ack);
        send_byte(sub, a);         chk({tag, " sub ack"}, a, exp_ack);
        for (int i = 0; i < n; i++) begin
            send_byte(dbuf[i], a); chk({tag, " data ack"}, a, exp_ack);
        end
        if (do_stop) begin
            bus_stop;
            wt(4);
        end
    endtask

    task automatic check_all(input string t);
        for (int c = 0; c < 3; c++) begin
            chk({t, " R9 offset"}, offset_code[c*9 +: 9], {model[3*c+1][7], model[3*c]});
            chk({t, " R9 coarse"}, coarse_gain[c*7 +: 7], model[3*c+1][6:0]);
            chk({t, " R9 fine"},   fine_gain[c*5 +: 5],   model[3*c+2][4:0]);
        end
        chk({t, " R11 ctrl"}, {coast_invert, hsync_invert, ref_fall_edge, pump_force_up,
                                pump_force_dn, pump_current}, model[9]);
        chk({t, " R11 filter"}, filter_res, model[10][7:5]);
        chk({t, " R11 vco"}, vco_range, model[10][4:3]);
        chk({t, " R10 div"}, div_ratio, {model[10][2:0], model[11], model[12][6]});
        chk({t, " R11 pha"}, {clk_a_select, phase_a}, model[12][5:0]);
        chk({t, " R11 phb"}, {clk_ab_swap, clk_b_select, phase_b}, model[13][6:0]);
        chk({t, " R12 released"}, sda_pull, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic a;
        for (int i = 0; i < 14; i++)
            model[i] = (i < 9) ? ((i % 3 == 0) ? 8'h7F : (i % 3 == 1) ? 8'h20 : 8'h00)
                     : (i == 9) ? 8'h04 : (i == 10) ? 8'h61 : (i == 11) ? 8'h90 : 8'h00;
        wt(5); rst = 1'b0; wt(5);

        // R8 reset defaults
        check_all("R8 reset");
        chk("R8 div default", div_ratio, 12'd800);

        // R1 address sweep, plus read request
        for (int s = 0; s < 4; s++) begin
            addr_sel = 2'(s);
            for (int d = 0; d < 4; d++) begin
                bus_start;
                send_byte({BASE[6:2], 2'(d), 1'b0}, a);
                chk("R1 address match", a, (d == s));
                bus_stop; wt(4);
            end
            bus_start;
            send_byte({BASE[6:2], 2'(s), 1'b1}, a);
            chk("R1 read request", a, 1'b0);
            bus_stop; wt(4);
        end
        addr_sel = 2'd2;

        // R1 unmatched address followed by bytes
        dbuf[0] = 8'h55;
        xfer("R1 foreign", {BASE[6:2], 2'd1}, 8'h00, 1, 1'b0, 1);
        check_all("R1 foreign");

        // R2 R3 single writes to every index, extra byte discarded
        for (int i = 0; i < 14; i++) begin
            dbuf[0] = 8'((i * 37 + 5) ^ 8'hA6);
            dbuf[1] = ~dbuf[0];
            xfer("R3 single", {BASE[6:2], 2'd2}, {4'h0, 4'(i)}, 2, 1'b1, 1);
            model[i] = dbuf[0];
            check_all("R3 single");
        end

        // R6 unused indices
        dbuf[0] = 8'hAA;
        xfer("R6 idx14", {BASE[6:2], 2'd2}, 8'h0E, 1, 1'b1, 1);
        xfer("R6 idx15", {BASE[6:2], 2'd2}, 8'h0F, 1, 1'b1, 1);
        check_all("R6 unused");

        // R4 full burst
        for (int i = 0; i < 14; i++) dbuf[i] = 8'(i * 29 + 7);
        xfer("R4 burst", {BASE[6:2], 2'd2}, 8'h1F, 14, 1'b1, 1);
        for (int i = 0; i < 14; i++) model[i] = dbuf[i];
        check_all("R4 burst");

        // R5 overrun: 16 bytes, last two ignored
        for (int i = 0; i < 16; i++) dbuf[i] = 8'(i * 53 + 200);
        xfer("R5 overrun", {BASE[6:2], 2'd2}, 8'h1F, 16, 1'b1, 1);
        for (int i = 0; i < 14; i++) model[i] = dbuf[i];
        check_all("R5 overrun");

        // R5 repeated start ends burst
        dbuf[0] = 8'h11; dbuf[1] = 8'h22; dbuf[2] = 8'h33;
        xfer("R5 rs burst", {BASE[6:2], 2'd2}, 8'h1F, 3, 1'b1, 0);
        model[0] = 8'h11; model[1] = 8'h22; model[2] = 8'h33;
        dbuf[0] = 8'h5A; dbuf[1] = 8'hC3;
        xfer("R5 rs single", {BASE[6:2], 2'd2}, 8'h05, 2, 1'b1, 1);
        model[5] = 8'h5A;
        check_all("R5 restart");

        // R10 divider at maximum
        dbuf[0] = 8'hFF;
        xfer("R10 vco", {BASE[6:2], 2'd2}, 8'h0A, 1, 1'b1, 1);
        xfer("R10 div", {BASE[6:2], 2'd2}, 8'h0B, 1, 1'b1, 1);
        xfer("R10 pha", {BASE[6:2], 2'd2}, 8'h0C, 1, 1'b1, 1);
        model[10] = 8'hFF; model[11] = 8'hFF; model[12] = 8'hFF;
        chk("R10 div max", div_ratio, 12'd4095);
        check_all("R10 max");

        // R7 disabled interface
        bus_off = 1'b1; wt(2);
        dbuf[0] = 8'h00;
        xfer("R7 off", {BASE[6:2], 2'd2}, 8'h0B, 1, 1'b0, 1);
        check_all("R7 off");
        bus_off = 1'b0; wt(4);

        // R2 mode flag with ordinary index acts as single write
        dbuf[0] = 8'h3C; dbuf[1] = 8'h99;
        xfer("R2 mode1 idx", {BASE[6:2], 2'd2}, 8'h19, 2, 1'b1, 1);
        model[9] = 8'h3C;
        check_all("R2 mode1");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule